// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets up to eleven processor subsystems pass short messages and doorbell interrupts to one another. Every channel has its own small register set: a doorbell register that raises interrupts at chosen targets, a view of which of its own doorbells are still unanswered, a pending-status register that the receiver clears, and an interrupt mask with separate enable and disable strobes. For every ordered sender/receiver pair there are two eight-word (32-byte) buffers: one carries the request and one carries the reply.

A typical exchange runs like this. The sender fills the pair's request buffer, then rings the doorbell for the receiver. The receiver's interrupt line goes high if that source is unmasked. The receiver reads the request and may write the reply buffer. It then clears the pending bit. The sender sees its unanswered bit drop and reads the reply. Any channel may start an exchange. Channels 3 to 6 belong to one management agent; every other channel is owned by the requester whose ID equals its index.

Access uses a word-addressed register bus tagged with a requester ID. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows on the next cycle. The response is held until `rsp_ready` is high. While a response is held, `req_ready` stays low, so the bus accepts no new request until the previous response has been taken.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset the block is in a defined idle state:
  - all pending bits are 0;
  - all mask bits are 1 (masked), so the mask of each channel reads 0x7FF;
  - every `irq` bit is low and `rsp_valid` is low.
- R2: The control window is addressed with word-address bit 12 = 0. Bits 6:3 give the channel and bits 2:0 give the register: 0 doorbell, 1 unanswered, 2 pending, 3 mask, 4 enable, 5 disable. When channel c writes its doorbell with bit r set, bit c of receiver r's pending register is set. Several targets may be rung in one write.
- R3: `irq[r]` is high exactly when receiver r has a pending bit that is set and not masked. Writing 1s to the enable register clears those mask bits. Writing 1s to the disable register sets them. The mask register reads back the current mask.
- R4: The pending register is write-1-to-clear, and only the written bits change. Bit r of channel c's unanswered register is 1 while bit c of receiver r's pending register is set, so it drops when the receiver clears that bit.
- R5: Ringing a doorbell whose pending bit is already set leaves it set and queues nothing. A single clear removes it.
- R6: The buffer window is addressed with word-address bit 12 = 1. Bits 11:8 give the sender, bits 7:4 the receiver, bit 3 selects the buffer (0 request, 1 reply) and bits 2:0 the word.
  - The sender writes the request buffer and the receiver reads it.
  - The receiver writes the reply buffer and the sender reads it.
  - Each pair's buffers are separate storage.
- R7: Buffer writes honour the four byte strobes; bytes whose strobe is 0 keep their old value.
- R8: A control window may be accessed only by its owner. Channels 3 to 6 are owned by the management ID (15 by default); any other channel c is owned by ID c. A refused access returns `rsp_err` = 1 with zero data and changes no state.
- R9: A buffer access is refused, with error, no state change and zero data, in any of these cases:
  - the requester is neither the pair's sender nor its receiver;
  - the requester writes the side it does not own;
  - the address names a channel of 11 or above.
- R10: Every accepted request gets exactly one response on the next cycle. While `rsp_ready` is low, the response stays valid and stable and `req_ready` is low, so no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 4 | Requester ID |
| req_addr | input | 13 | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for buffer writes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Access refused |
| irq | output | 11 | Per-receiver interrupt lines |

## Verification
The doorbell path is tried in several ways:
- a single target rung from one sender;
- two targets rung in one write;
- two senders pending at the same receiver, one of which is cleared.

Together these separate the pending bit of the receiver from the unanswered view of the sender. Mask toggling with pending bits set shows that the interrupt follows the mask and not only the pending state. A repeated ring followed by one clear shows that nothing is queued.

Buffer traffic is tried in both directions between two pairs, plus a partial-strobe write. Refused accesses are followed by read-back through a legal owner, which proves they changed nothing. A stalled response with a competing request shows that back-pressure blocks acceptance.

// File: rtl/ipi_mbx_pkg.sv
package ipi_mbx_pkg;
  typedef enum logic [2:0] {
    REG_TRIG = 3'd0,
    REG_OBS  = 3'd1,
    REG_ISR  = 3'd2,
    REG_IMR  = 3'd3,
    REG_IER  = 3'd4,
    REG_IDR  = 3'd5,
    REG_RSV6 = 3'd6,
    REG_RSV7 = 3'd7
  } mbx_reg_e;
endpackage

// File: rtl/ipi_mbx_decode.sv
module ipi_mbx_decode
  import ipi_mbx_pkg::*;
#(
  parameter int unsigned NCH = 11,
  parameter int unsigned CW = 4,
  parameter int unsigned IDW = 4,
  parameter logic [IDW-1:0] MGMT_ID = '1,
  parameter int unsigned RSV_LO = 3,
  parameter int unsigned RSV_HI = 6,
  parameter int unsigned WORDS = 8,
  parameter int unsigned WW = 3,
  parameter int unsigned AW = 13,
  parameter int unsigned MIW = 11
) (
  input  logic [AW-1:0]  addr,
  input  logic [IDW-1:0] id,
  input  logic           write,
  output logic           ok,
  output logic           is_buf,
  output logic [CW-1:0]  ch,
  output mbx_reg_e       reg_sel,
  output logic [MIW-1:0] mem_idx
);
  function automatic logic [IDW-1:0] owner_of(input logic [CW-1:0] c);
    if (int'(c) >= int'(RSV_LO) && int'(c) <= int'(RSV_HI)) return MGMT_ID;
    return IDW'(c);
  endfunction

  logic [CW-1:0] snd, rcv;
  logic          side;
  logic [WW-1:0] word;
  logic          ctrl_ok, buf_ok, snd_own, rcv_own, in_range;

  assign is_buf  = addr[AW-1];
  assign snd     = addr[AW-2 -: CW];
  assign rcv     = addr[AW-2-CW -: CW];
  assign side    = addr[WW];
  assign word    = addr[WW-1:0];
  assign ch      = addr[3 +: CW];
  assign reg_sel = mbx_reg_e'(addr[2:0]);

  assign ctrl_ok  = (int'(ch) < int'(NCH)) && (owner_of(ch) == id) && (addr[2:0] <= 3'd5);
  assign in_range = (int'(snd) < int'(NCH)) && (int'(rcv) < int'(NCH));
  assign snd_own  = owner_of(snd) == id;
  assign rcv_own  = owner_of(rcv) == id;

  always_comb begin
    if (!in_range)   buf_ok = 1'b0;
    else if (write)  buf_ok = side ? rcv_own : snd_own;
    else             buf_ok = snd_own || rcv_own;
  end

  assign ok = is_buf ? buf_ok : ctrl_ok;

  always_comb begin
    if (is_buf && buf_ok)
      mem_idx = MIW'(((int'(snd) * int'(NCH) + int'(rcv)) * 2 + int'(side)) * int'(WORDS) + int'(word));
    else
      mem_idx = '0;
  end
endmodule

// File: rtl/ipi_mbx_ctrl.sv
module ipi_mbx_ctrl
  import ipi_mbx_pkg::*;
#(
  parameter int unsigned NCH = 11,
  parameter int unsigned CW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CW-1:0]  ch,
  input  mbx_reg_e       reg_sel,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] pend_q [NCH];
  logic [NCH-1:0] mask_q [NCH];

  for (genvar r = 0; r < NCH; r++) begin : g_rx
    logic self_sel;
    assign self_sel = int'(ch) == r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[r] <= '0;
        mask_q[r] <= '1;
      end else if (wr_en) begin
        case (reg_sel)
          REG_TRIG: if (wdata[r]) pend_q[r][ch] <= 1'b1;
          REG_ISR:  if (self_sel) pend_q[r] <= pend_q[r] & ~wdata;
          REG_IER:  if (self_sel) mask_q[r] <= mask_q[r] & ~wdata;
          REG_IDR:  if (self_sel) mask_q[r] <= mask_q[r] | wdata;
          default: ;
        endcase
      end
    end

    assign irq[r] = |(pend_q[r] & ~mask_q[r]);
  end

  always_comb begin
    rdata = '0;
    case (reg_sel)
      REG_OBS: for (int r = 0; r < int'(NCH); r++) rdata[r] = pend_q[r][ch];
      REG_ISR: rdata = pend_q[ch];
      REG_IMR: rdata = mask_q[ch];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ipi_mbx_buf.sv
module ipi_mbx_buf #(
  parameter int unsigned DEPTH = 1936,
  parameter int unsigned MIW = 11,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = DW / 8
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [MIW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  input  logic [SW-1:0]  strb,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < int'(SW); b++) begin
        if (strb[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbx_pkg::*;
#(
  parameter int unsigned NCH = 11,
  parameter int unsigned IDW = 4,
  parameter logic [IDW-1:0] MGMT_ID = '1,
  parameter int unsigned RSV_LO = 3,
  parameter int unsigned RSV_HI = 6,
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW = 32,
  localparam int unsigned CW = $clog2(NCH),
  localparam int unsigned WW = $clog2(WORDS),
  localparam int unsigned AW = 2 * CW + WW + 2,
  localparam int unsigned SW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [SW-1:0]  req_strb,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_err,
  output logic [NCH-1:0] irq
);
  localparam int unsigned DEPTH = NCH * NCH * 2 * WORDS;
  localparam int unsigned MIW = $clog2(DEPTH);

  logic           accept, ok, is_buf;
  logic [CW-1:0]  ch;
  mbx_reg_e       reg_sel;
  logic [MIW-1:0] mem_idx;
  logic [NCH-1:0] ctrl_rd;
  logic [DW-1:0]  buf_rd, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  ipi_mbx_decode #(
    .NCH(NCH), .CW(CW), .IDW(IDW), .MGMT_ID(MGMT_ID), .RSV_LO(RSV_LO),
    .RSV_HI(RSV_HI), .WORDS(WORDS), .WW(WW), .AW(AW), .MIW(MIW)
  ) u_dec (
    .addr(req_addr), .id(req_id), .write(req_write), .ok(ok),
    .is_buf(is_buf), .ch(ch), .reg_sel(reg_sel), .mem_idx(mem_idx)
  );

  ipi_mbx_ctrl #(.NCH(NCH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && req_write && ok && !is_buf),
    .ch(ch), .reg_sel(reg_sel), .wdata(req_wdata[NCH-1:0]),
    .rdata(ctrl_rd), .irq(irq)
  );

  ipi_mbx_buf #(.DEPTH(DEPTH), .MIW(MIW), .DW(DW), .SW(SW)) u_buf (
    .clk(clk), .wr_en(accept && req_write && ok && is_buf),
    .idx(mem_idx), .wdata(req_wdata), .strb(req_strb), .rdata(buf_rd)
  );

  always_comb begin
    if (!ok || req_write) rd_mux = '0;
    else if (is_buf)      rd_mux = buf_rd;
    else                  rd_mux = DW'(ctrl_rd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= !ok;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int unsigned NCH = 11,
  parameter int unsigned DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DW-1:0]  rsp_rdata,
  input logic           rsp_err,
  input logic [NCH-1:0] irq
);
  // R10: a stalled response holds its contents
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R10: no acceptance while a response is stalled
  a_r10_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R10: an accepted request yields a response next cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R8: refused accesses return zero data
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);

  // R3: an interrupt line only changes after an accepted write
  a_r3_irq_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq != $past(irq) |-> $past(req_valid && req_ready && req_write));
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
);

// File: tb/test_ipi_mailbox.sv
module test_ipi_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_id = '0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [10:0] irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_mailbox i_ipi_mailbox (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_id(req_id), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  function automatic logic [12:0] ca(input int c, input int r);
    return {1'b0, 5'b0, 4'(c), 3'(r)};
  endfunction

  function automatic logic [12:0] ba(input int s, input int r, input int rep, input int w);
    return {1'b1, 4'(s), 4'(r), 1'(rep), 3'(w)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input int id, input logic [12:0] a,
                      input logic [31:0] wd, input logic [3:0] st,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_id = 4'(id); req_addr = a;
    req_wdata = wd; req_strb = st; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic wr_ok(input string tag, input int id, input logic [12:0] a,
                       input logic [31:0] wd, input logic [3:0] st);
    logic [31:0] rd; logic er;
    xfer(1'b1, id, a, wd, st, rd, er);
    check(tag, 32'(er), 32'd0);
  endtask

  task automatic rd_chk(input string tag, input int id, input logic [12:0] a,
                        input logic [31:0] exp);
    logic [31:0] rd; logic er;
    xfer(1'b0, id, a, '0, '0, rd, er);
    check(tag, {31'd0, er}, 32'd0);
    check(tag, rd, exp);
  endtask

  task automatic refused(input string tag, input logic wr, input int id,
                         input logic [12:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    xfer(wr, id, a, wd, 4'hF, rd, er);
    check(tag, {31'd0, er}, 32'd1);
    check(tag, rd, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rd_chk("R1 pend", 1, ca(1, 2), 32'h0);
    rd_chk("R1 mask", 0, ca(0, 3), 32'h7FF);
  endtask

  task automatic t_trigger;
    wr_ok("R2 ring", 0, ca(0, 0), 32'h006, 4'hF);
    rd_chk("R2 pend ch1", 1, ca(1, 2), 32'h001);
    rd_chk("R2 pend ch2", 2, ca(2, 2), 32'h001);
    rd_chk("R4 obs ch0", 0, ca(0, 1), 32'h006);
    check("R2 masked irq", 32'(irq), 32'd0);
  endtask

  task automatic t_mask;
    wr_ok("R3 enable", 1, ca(1, 4), 32'h001, 4'hF);
    check("R3 irq on", 32'(irq), 32'h002);
    rd_chk("R3 mask rb", 1, ca(1, 3), 32'h7FE);
    wr_ok("R3 disable", 1, ca(1, 5), 32'h001, 4'hF);
    check("R3 irq off", 32'(irq), 32'h000);
    wr_ok("R3 reenable", 1, ca(1, 4), 32'h001, 4'hF);
    check("R3 irq again", 32'(irq), 32'h002);
  endtask

  task automatic t_clear;
    wr_ok("R4 ring7", 7, ca(7, 0), 32'h002, 4'hF);
    rd_chk("R4 pend two", 1, ca(1, 2), 32'h081);
    wr_ok("R4 clear", 1, ca(1, 2), 32'h001, 4'hF);
    rd_chk("R4 pend left", 1, ca(1, 2), 32'h080);
    rd_chk("R4 obs0 drop", 0, ca(0, 1), 32'h004);
    rd_chk("R4 obs7 kept", 7, ca(7, 1), 32'h002);
    check("R4 irq after clear", 32'(irq), 32'h000);
  endtask

  task automatic t_retrigger;
    wr_ok("R5 ring a", 0, ca(0, 0), 32'h002, 4'hF);
    wr_ok("R5 ring b", 0, ca(0, 0), 32'h002, 4'hF);
    rd_chk("R5 pend", 1, ca(1, 2), 32'h081);
    wr_ok("R5 clear", 1, ca(1, 2), 32'h001, 4'hF);
    rd_chk("R5 no queue", 1, ca(1, 2), 32'h080);
    check("R5 irq", 32'(irq), 32'h000);
  endtask

  task automatic t_reserved;
    refused("R8 non-mgmt rd", 1'b0, 4, ca(4, 2), '0);
    rd_chk("R8 mgmt rd", 15, ca(4, 2), 32'h0);
    wr_ok("R8 mgmt ring", 15, ca(5, 0), 32'h002, 4'hF);
    refused("R8 foreign ring", 1'b1, 2, ca(0, 0), 32'h002);
    refused("R8 mgmt on ch0", 1'b0, 15, ca(0, 2), '0);
    rd_chk("R8 pend unchanged", 1, ca(1, 2), 32'h0A0);
  endtask

  task automatic t_buffers;
    for (int w = 0; w < 8; w++)
      wr_ok("R6 req wr", 0, ba(0, 1, 0, w), 32'hA000_0000 + 32'(w), 4'hF);
    wr_ok("R6 other pair", 2, ba(2, 1, 0, 0), 32'h5555_0000, 4'hF);
    for (int w = 0; w < 8; w++)
      rd_chk("R6 req rd", 1, ba(0, 1, 0, w), 32'hA000_0000 + 32'(w));
    wr_ok("R6 rsp wr", 1, ba(0, 1, 1, 3), 32'hBEEF_0003, 4'hF);
    rd_chk("R6 rsp rd", 0, ba(0, 1, 1, 3), 32'hBEEF_0003);
    rd_chk("R6 pair sep", 1, ba(2, 1, 0, 0), 32'h5555_0000);
  endtask

  task automatic t_strobe;
    wr_ok("R7 base", 0, ba(0, 1, 0, 5), 32'h1122_3344, 4'hF);
    wr_ok("R7 partial", 0, ba(0, 1, 0, 5), 32'hAABB_CCDD, 4'b0101);
    rd_chk("R7 merge", 1, ba(0, 1, 0, 5), 32'h11BB_33DD);
  endtask

  task automatic t_buf_perm;
    refused("R9 rx writes req", 1'b1, 1, ba(0, 1, 0, 0), 32'hDEAD_DEAD);
    refused("R9 tx writes rsp", 1'b1, 0, ba(0, 1, 1, 3), 32'hDEAD_DEAD);
    refused("R9 outsider rd", 1'b0, 9, ba(0, 1, 0, 0), '0);
    refused("R9 range", 1'b0, 0, ba(0, 12, 0, 0), '0);
    rd_chk("R9 req kept", 0, ba(0, 1, 0, 0), 32'hA000_0000);
    rd_chk("R9 rsp kept", 1, ba(0, 1, 1, 3), 32'hBEEF_0003);
  endtask

  task automatic t_backpressure;
    logic [31:0] d0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_id = 4'd1; req_addr = ca(1, 2);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    d0 = rsp_rdata;
    check("R10 rsp valid", 32'(rsp_valid), 32'd1);
    check("R10 data", d0, 32'h0A0);
    check("R10 not ready", 32'(req_ready), 32'd0);
    req_valid = 1'b1; req_write = 1'b1; req_id = 4'd0; req_addr = ca(0, 0);
    req_wdata = 32'h200;
    @(negedge clk);
    check("R10 held", 32'(rsp_valid), 32'd1);
    check("R10 stable", rsp_rdata, d0);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 32'd0);
    rd_chk("R10 blocked req", 9, ca(9, 2), 32'h0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_mask();
    t_clear();
    t_retrigger();
    t_reserved();
    t_buffers();
    t_strobe();
    t_buf_perm();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule